// File: doc/BRIEF.md
# Data-Flash Page Erase and Byte Program Controller

This block manages a small non-volatile data area that is mapped into the code address space of an 8-bit processor. Software reaches it through three register ports on a simple write strobe: an operand address register (only the low byte is kept), a data register and a command register. Setting the erase command bit starts a page erase. Setting the program command bit starts a single-byte program. While either operation runs, the block raises a hold that freezes instruction fetch and the program counter. The command bit stays set for the whole operation and hardware clears it when the operation ends, so the command register also serves as the busy indication.

Reads do not go through the command registers. They go through the code-fetch read port: any code address inside the window at `WIN_BASE` (FC00h by default, 256 bytes as four 64-byte pages) returns the stored byte combinationally. Erase sets every byte of one page to FFh. Program can only clear bits (new = old AND data), so a location has to be erased before it can take an arbitrary value. The erase and program durations are counted in clock cycles and are set by parameters.

Top module: `dfl_ctrl_top`

## Requirements
- R1: After reset the command register reads 00h, `cpu_hold` is low and every byte of the window reads FFh.
- R2: A code address from `WIN_BASE` to `WIN_BASE`+255 sets `win_hit` and returns the stored byte on `code_rdata` in the same cycle. Any other address clears `win_hit` and returns 00h.
- R3: Writing the command register (select 2) with bit 7 set erases the page selected by operand address bits [7:6]: all 64 bytes of that page become FFh, bits [5:0] of the operand address are ignored, and the other pages keep their contents.
- R4: Writing the command register with bit 6 set (bit 7 clear) programs the byte at window offset equal to the operand address. The stored value becomes the old value AND the data register (select 1). The address register is select 0.
- R5: `cpu_hold` is high for exactly `ERASE_CYCLES` cycles after an erase command and exactly `PROG_CYCLES` cycles after a program command. It is high exactly while a command bit reads set.
- R6: The command register reads bit 7 for a running erase and bit 6 for a running program, and hardware clears the bit at completion. Bits [5:0] always read 0, and writing only those bits starts nothing.
- R7: A command write with both bits 7 and 6 set performs only the erase.
- R8: While an operation runs, writes to any of the three registers are ignored: no second command starts and the latched address and data stay unchanged.
- R9: The array content visible on the read port changes only at the clock edge that ends an operation. While the operation runs, reads return the old values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 address, 1 data, 2 command |
| reg_wdata | input | 8 | Register write data |
| ctrl_rdata | output | 8 | Command register readback (bit 7 erase busy, bit 6 program busy) |
| code_addr | input | 16 | Code-fetch read address |
| code_rdata | output | 8 | Byte read from the window, 00h outside it |
| win_hit | output | 1 | Code address falls in the data window |
| cpu_hold | output | 1 | Freezes instruction fetch and program counter |

## Verification
The program path is tried on a freshly erased byte, which shows the stored value equal to the data, and then again on the same byte, which separates an AND merge from a plain overwrite. Erases are issued with a non-zero in-page offset and on the first and last pages, with a programmed byte left in another page, which shows whether page selection uses the right address bits and leaves neighbours alone. A combined erase-plus-program command, and register writes made during a busy erase, are each followed by reads of the bytes the unwanted action would have changed and of the command register. Reads in the middle of an operation and at its last busy cycle fix the exact completion edge.

// File: rtl/dfl_pkg.sv
package dfl_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_ERASE = 2'd1,
    OP_PROG  = 2'd2
  } dfl_op_e;

  localparam logic [1:0] SEL_ADDR = 2'd0;
  localparam logic [1:0] SEL_DATA = 2'd1;
  localparam logic [1:0] SEL_CMD  = 2'd2;

  localparam int CMD_ERASE_BIT = 7;
  localparam int CMD_PROG_BIT  = 6;
endpackage

// File: rtl/dfl_timer.sv
module dfl_timer #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = load_val;
    else if (run && (cnt_q != '0))
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else
      cnt_q <= cnt_d;
  end

  assign expired = run && (cnt_q == '0);
endmodule

// File: rtl/dfl_regs.sv
module dfl_regs
  import dfl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr_en,
  input  logic [1:0] reg_sel,
  input  logic [7:0] reg_wdata,
  input  logic       op_done,
  output dfl_op_e    op,
  output logic       op_start,
  output logic [7:0] opnd_addr,
  output logic [7:0] opnd_data
);
  dfl_op_e    op_q, op_d;
  logic [7:0] addr_q, addr_d;
  logic [7:0] data_q, data_d;
  logic       idle;
  logic       cmd_wr;

  assign idle   = (op_q == OP_IDLE);
  assign cmd_wr = reg_wr_en && idle && (reg_sel == SEL_CMD) &&
                  (reg_wdata[CMD_ERASE_BIT] || reg_wdata[CMD_PROG_BIT]);

  always_comb begin
    op_d   = op_q;
    addr_d = addr_q;
    data_d = data_q;
    if (reg_wr_en && idle && (reg_sel == SEL_ADDR))
      addr_d = reg_wdata;
    if (reg_wr_en && idle && (reg_sel == SEL_DATA))
      data_d = reg_wdata;
    if (cmd_wr)
      op_d = reg_wdata[CMD_ERASE_BIT] ? OP_ERASE : OP_PROG;
    else if (op_done)
      op_d = OP_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_IDLE;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      op_q   <= op_d;
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end

  assign op        = op_q;
  assign op_start  = cmd_wr;
  assign opnd_addr = addr_q;
  assign opnd_data = data_q;
endmodule

// File: rtl/dfl_array.sv
module dfl_array
  import dfl_pkg::*;
#(
  parameter int PAGES      = 4,
  parameter int PAGE_BYTES = 64
) (
  input  logic                                       clk,
  input  logic                                       rst_n,
  input  logic                                       commit,
  input  dfl_op_e                                    op,
  input  logic [$clog2(PAGES*PAGE_BYTES)-1:0]        tgt_idx,
  input  logic [7:0]                                 tgt_data,
  input  logic [$clog2(PAGES*PAGE_BYTES)-1:0]        rd_idx,
  output logic [7:0]                                 rd_data
);
  localparam int BYTES = PAGES * PAGE_BYTES;
  localparam int IDX_W = $clog2(BYTES);
  localparam int OFF_W = $clog2(PAGE_BYTES);

  logic [7:0] mem_q [BYTES];

  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    logic [7:0] byte_d;
    logic       page_sel;
    logic       byte_sel;
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(b);

    assign page_sel = (tgt_idx[IDX_W-1:OFF_W] == MY_IDX[IDX_W-1:OFF_W]);
    assign byte_sel = (tgt_idx == MY_IDX);

    always_comb begin
      byte_d = mem_q[b];
      if (commit && (op == OP_ERASE) && page_sel)
        byte_d = 8'hFF;
      else if (commit && (op == OP_PROG) && byte_sel)
        byte_d = mem_q[b] & tgt_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mem_q[b] <= 8'hFF;
      else
        mem_q[b] <= byte_d;
    end
  end

  assign rd_data = mem_q[rd_idx];
endmodule

// File: rtl/dfl_ctrl_top.sv
module dfl_ctrl_top
  import dfl_pkg::*;
#(
  parameter int          PAGES        = 4,
  parameter int          PAGE_BYTES   = 64,
  parameter int          ADDR_W       = 16,
  parameter logic [15:0] WIN_BASE     = 16'hFC00,
  parameter int          ERASE_CYCLES = 625000,
  parameter int          PROG_CYCLES  = 6250
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [1:0]        reg_sel,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        ctrl_rdata,
  input  logic [ADDR_W-1:0] code_addr,
  output logic [7:0]        code_rdata,
  output logic              win_hit,
  output logic              cpu_hold
);
  localparam int BYTES   = PAGES * PAGE_BYTES;
  localparam int IDX_W   = $clog2(BYTES);
  localparam int MAX_CYC = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [ADDR_W:0] WIN_LO = (ADDR_W+1)'(WIN_BASE);
  localparam logic [ADDR_W:0] WIN_HI = (ADDR_W+1)'(WIN_BASE) + (ADDR_W+1)'(BYTES);

  dfl_op_e          op;
  logic             op_start;
  logic             op_done;
  logic             busy;
  logic [7:0]       opnd_addr;
  logic [7:0]       opnd_data;
  logic [CNT_W-1:0] load_val;
  logic [7:0]       arr_rdata;
  logic [ADDR_W:0]  addr_ext;

  dfl_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr_en (reg_wr_en),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .op_done   (op_done),
    .op        (op),
    .op_start  (op_start),
    .opnd_addr (opnd_addr),
    .opnd_data (opnd_data)
  );

  assign busy     = (op != OP_IDLE);
  assign load_val = reg_wdata[CMD_ERASE_BIT] ? CNT_W'(ERASE_CYCLES - 1)
                                              : CNT_W'(PROG_CYCLES - 1);

  dfl_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (op_start),
    .load_val (load_val),
    .run      (busy),
    .expired  (op_done)
  );

  dfl_array #(.PAGES(PAGES), .PAGE_BYTES(PAGE_BYTES)) u_array (
    .clk      (clk),
    .rst_n    (rst_n),
    .commit   (op_done),
    .op       (op),
    .tgt_idx  (opnd_addr[IDX_W-1:0]),
    .tgt_data (opnd_data),
    .rd_idx   (code_addr[IDX_W-1:0]),
    .rd_data  (arr_rdata)
  );

  assign addr_ext   = {1'b0, code_addr};
  assign win_hit    = (addr_ext >= WIN_LO) && (addr_ext < WIN_HI);
  assign code_rdata = win_hit ? arr_rdata : 8'h00;
  assign cpu_hold   = busy;
  assign ctrl_rdata = {op == OP_ERASE, op == OP_PROG, 6'b0};
endmodule

// File: rtl/dfl_ctrl_chk.sv
module dfl_ctrl_chk #(
  parameter int ADDR_W       = 16,
  parameter int ERASE_CYCLES = 625000,
  parameter int PROG_CYCLES  = 6250
) (
  input logic              clk,
  input logic              rst_n,
  input logic [7:0]        ctrl_rdata,
  input logic              cpu_hold,
  input logic [ADDR_W-1:0] code_addr,
  input logic [7:0]        code_rdata,
  input logic              win_hit
);
  logic [31:0] run_q;
  logic        was_erase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q       <= '0;
      was_erase_q <= 1'b0;
    end else if (cpu_hold) begin
      run_q       <= run_q + 1;
      was_erase_q <= ctrl_rdata[7];
    end else begin
      run_q       <= '0;
    end
  end

  p_hold_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_hold == (ctrl_rdata[7] || ctrl_rdata[6]));

  p_hold_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_hold) |-> (run_q == (was_erase_q ? ERASE_CYCLES : PROG_CYCLES)));

  p_one_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ctrl_rdata[7:6]));

  p_low_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rdata[5:0] == 6'b0);

  p_miss_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !win_hit |-> (code_rdata == 8'h00));

  p_busy_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_hold && $past(cpu_hold)) |-> $stable(ctrl_rdata));

  p_read_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_hold && $past(cpu_hold) && $stable(code_addr)) |-> $stable(code_rdata));
endmodule

bind dfl_ctrl_top dfl_ctrl_chk #(
  .ADDR_W       (ADDR_W),
  .ERASE_CYCLES (ERASE_CYCLES),
  .PROG_CYCLES  (PROG_CYCLES)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ctrl_rdata (ctrl_rdata),
  .cpu_hold   (cpu_hold),
  .code_addr  (code_addr),
  .code_rdata (code_rdata),
  .win_hit    (win_hit)
);

// File: tb/tb_dfl_ctrl_top.sv
module tb_dfl_ctrl_top;
  localparam int ER_N = 20;
  localparam int PG_N = 5;

  typedef struct {
    int          kind;
    logic [7:0]  exp;
    logic        hit;
    string       req;
  } item_t;

  logic        clk;
  logic        rst_n;
  logic        reg_wr_en;
  logic [1:0]  reg_sel;
  logic [7:0]  reg_wdata;
  logic [7:0]  ctrl_rdata;
  logic [15:0] code_addr;
  logic [7:0]  code_rdata;
  logic        win_hit;
  logic        cpu_hold;

  int    n_checks = 0;
  int    n_fail   = 0;
  bit    finished = 0;
  item_t sb_q[$];

  dfl_ctrl_top #(.ERASE_CYCLES(ER_N), .PROG_CYCLES(PG_N)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .ctrl_rdata(ctrl_rdata), .code_addr(code_addr),
    .code_rdata(code_rdata), .win_hit(win_hit), .cpu_hold(cpu_hold)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // monitor: pops expected items at the falling edge
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      n_checks++;
      case (it.kind)
        0: if (code_rdata !== it.exp || win_hit !== it.hit) begin
             n_fail++;
             $display("FAIL %s read addr %h: got data %h hit %b, expected data %h hit %b",
                      it.req, code_addr, code_rdata, win_hit, it.exp, it.hit);
           end
        1: if (ctrl_rdata !== it.exp) begin
             n_fail++;
             $display("FAIL %s ctrl: got %h, expected %h", it.req, ctrl_rdata, it.exp);
           end
        default: if (cpu_hold !== it.hit) begin
             n_fail++;
             $display("FAIL %s hold: got %b, expected %b", it.req, cpu_hold, it.hit);
           end
      endcase
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic chk_read(logic [15:0] a, logic [7:0] e, logic h, string r);
    item_t it;
    code_addr = a;
    it.kind = 0; it.exp = e; it.hit = h; it.req = r;
    sb_q.push_back(it);
    step(1);
  endtask

  task automatic chk_ctrl(logic [7:0] e, string r);
    item_t it;
    it.kind = 1; it.exp = e; it.hit = 1'b0; it.req = r;
    sb_q.push_back(it);
    step(1);
  endtask

  task automatic chk_hold(logic h, string r);
    item_t it;
    it.kind = 2; it.exp = 8'h00; it.hit = h; it.req = r;
    sb_q.push_back(it);
    step(1);
  endtask

  task automatic wr(logic [1:0] s, logic [7:0] d);
    reg_wr_en = 1'b1; reg_sel = s; reg_wdata = d;
    step(1);
    reg_wr_en = 1'b0;
  endtask

  // start a command, check busy state, old read data, and exact completion
  task automatic run_op(logic [7:0] cmd, logic [7:0] busy_val, int n,
                        logic [15:0] a, logic [7:0] old_v, logic [7:0] new_v, string r);
    wr(2'd2, cmd);
    chk_ctrl(busy_val, r);
    chk_hold(1'b1, "R5");
    chk_read(a, old_v, 1'b1, "R9");
    step(n - 4);
    chk_ctrl(busy_val, "R5");
    chk_ctrl(8'h00, "R6");
    chk_read(a, new_v, 1'b1, r);
  endtask

  initial begin
    rst_n = 1'b0; reg_wr_en = 1'b0; reg_sel = 2'd0; reg_wdata = 8'h00;
    code_addr = 16'h0000;
    step(3);
    rst_n = 1'b1;
    step(1);

    // R1 reset state
    chk_ctrl(8'h00, "R1");
    chk_hold(1'b0, "R1");
    chk_read(16'hFC00, 8'hFF, 1'b1, "R1");
    chk_read(16'hFCFF, 8'hFF, 1'b1, "R1");
    // R2 window edges
    chk_read(16'hFBFF, 8'h00, 1'b0, "R2");
    chk_read(16'hFD00, 8'h00, 1'b0, "R2");
    chk_read(16'h1234, 8'h00, 1'b0, "R2");

    // R4 program on erased byte, then AND merge
    wr(2'd0, 8'h05); wr(2'd1, 8'hA5);
    run_op(8'h40, 8'h40, PG_N, 16'hFC05, 8'hFF, 8'hA5, "R4");
    wr(2'd1, 8'h3C);
    run_op(8'h40, 8'h40, PG_N, 16'hFC05, 8'hA5, 8'h24, "R4");

    // R3 erase page 1 with nonzero in-page offset
    wr(2'd0, 8'h45); wr(2'd1, 8'h00);
    run_op(8'h40, 8'h40, PG_N, 16'hFC45, 8'hFF, 8'h00, "R4");
    wr(2'd0, 8'h47);
    wr(2'd1, 8'h0F);
    run_op(8'h80, 8'h80, ER_N, 16'hFC45, 8'h00, 8'hFF, "R3");
    chk_read(16'hFC05, 8'h24, 1'b1, "R3");

    // R8 writes during a busy erase are ignored
    wr(2'd2, 8'h80);              // edge E
    wr(2'd0, 8'h10);              // E+1
    wr(2'd1, 8'h00);              // E+2
    wr(2'd2, 8'h40);              // E+3, now in cycle E+3
    step(ER_N - 4);               // cycle E+19
    chk_ctrl(8'h80, "R8");
    chk_ctrl(8'h00, "R8");
    chk_hold(1'b0, "R8");
    run_op(8'h40, 8'h40, PG_N, 16'hFC47, 8'hFF, 8'h0F, "R8");
    chk_read(16'hFC10, 8'hFF, 1'b1, "R8");

    // R7 both command bits: erase only
    wr(2'd0, 8'h05); wr(2'd1, 8'h00);
    run_op(8'hC0, 8'h80, ER_N, 16'hFC05, 8'h24, 8'hFF, "R7");

    // R6 low bits alone start nothing
    wr(2'd2, 8'h3F);
    chk_ctrl(8'h00, "R6");
    chk_hold(1'b0, "R6");

    // R3 last page erase, neighbour page kept
    wr(2'd0, 8'hFF); wr(2'd1, 8'h12);
    run_op(8'h40, 8'h40, PG_N, 16'hFCFF, 8'hFF, 8'h12, "R4");
    wr(2'd0, 8'hBF); wr(2'd1, 8'h34);
    run_op(8'h40, 8'h40, PG_N, 16'hFCBF, 8'hFF, 8'h34, "R4");
    wr(2'd0, 8'hC0);
    run_op(8'h80, 8'h80, ER_N, 16'hFCFF, 8'h12, 8'hFF, "R3");
    chk_read(16'hFCBF, 8'h34, 1'b1, "R3");
    chk_read(16'hFCC0, 8'hFF, 1'b1, "R3");

    step(2);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule